// File: doc/BRIEF.md
# NAND Copyback Command Sequencer

This block runs a full on-die page copy on a NAND flash device over an 8-bit multiplexed bus. A one-clock start pulse, a source row, a destination row and a short list of byte patches are enough. The sequencer first loads the source page into the device cache. It waits for the device to become ready, then optionally rewrites chosen bytes of the cached page. It then starts programming of the destination page. Finally it waits for the program to finish and reports the result.

Readiness is taken either from the ready/busy line or by polling the device status byte. A mode input picks which one. Every busy wait is bounded by a programmable clock count, and an expired wait ends the operation with a timeout flag. A request whose source and destination lie on different dies is refused at once, without any bus activity.

Top module: `nand_copyback_seq`

## Requirements
- R1: Out of reset, and while idle, the bus rests with we_no=1, re_no=1, cle_o=0, ale_o=0 and io_oe_o=0. done_o and busy_o are 0.
- R2: After an accepted start, the first bus cycles are command 00h, then five address cycles, then command 35h. The five address cycles are column low and column high (both 00h), then source row bytes [7:0], [15:8] and [23:16].
- R3: In ready/busy mode (poll_mode_i=0), the command 85h is never issued while rb_ni is low after 35h.
- R4: The program part is command 85h, then 00h, 00h, then destination row bytes low to high, then after any patches command 10h. The total cycle count matches exactly.
- R5: Each patch k, for k below patch_cnt_i, is written in index order between the destination address and 10h. A patch is command 85h, column bytes low then high from patch_col_i[16k+:16], then one data cycle with patch_dat_i[8k+:8]. A patch_cnt_i above the patch capacity (4) is clamped to 4.
- R6: A start whose die bit differs between the rows (row bit 23) gives done_o and die_err_o on the next clock, with no bus cycle.
- R7: In poll mode, each wait issues command 70h once, then repeats status reads until bit 6 of the status byte is 1. In ready/busy mode, 70h and a single status read are issued only after the program wait.
- R8: pass_o is 1 when bit 0 of the final status byte is 0, and 0 otherwise.
- R9: A wait longer than timeout_i clocks ends the operation with tmo_err_o=1 and pass_o=0. A timeout after 35h means no later command is issued.
- R10: WE# stays low for we_low_i clocks in each write cycle, with 0 treated as 1. CLE, ALE and data are held for one clock after WE# rises.
- R11: done_o is a one-clock pulse. The result flags hold until the next start, and start_i has no effect while busy_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| src_row_i | input | 24 | Source row address, bit 23 is the die bit |
| dst_row_i | input | 24 | Destination row address, bit 23 is the die bit |
| patch_cnt_i | input | 3 | Number of patches to apply |
| patch_col_i | input | 64 | Patch columns, 16 bits each; held stable while busy |
| patch_dat_i | input | 32 | Patch data bytes; held stable while busy |
| poll_mode_i | input | 1 | 1: status polling, 0: ready/busy line |
| we_low_i | input | 4 | WE#/RE# low width in clocks |
| timeout_i | input | 16 | Busy wait limit in clocks |
| rb_ni | input | 1 | Device ready (1) / busy (0) |
| io_i | input | 8 | Data from the device (status byte) |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write enable, active low |
| re_no | output | 1 | Read enable, active low |
| io_o | output | 8 | Data to the device |
| io_oe_o | output | 1 | Output enable for io_o |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| pass_o | output | 1 | Program result, 1 = pass |
| die_err_o | output | 1 | Die mismatch refusal |
| tmo_err_o | output | 1 | Busy wait timed out |

## Verification
The hardest situation to reach is the exact gate between the two halves. The 85h command must follow the device leaving busy, and never come before it. A wait may also run out while status reads are still going on. The bench models the device's busy time per run and records every latched cycle at the pins. It flags any 85h latched while its model is busy. Long busy times paired with short limits drive both wait modes into the timeout branch.

// File: rtl/nand_cb_pkg.sv
package nand_cb_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADR, CYC_DAT, CYC_RD} cyc_kind_e;

  localparam logic [7:0] OP_LOAD     = 8'h00;
  localparam logic [7:0] OP_LOAD_CFM = 8'h35;
  localparam logic [7:0] OP_WRITE    = 8'h85;
  localparam logic [7:0] OP_WRITE_GO = 8'h10;
  localparam logic [7:0] OP_STAT     = 8'h70;

  localparam int STAT_RDY = 6;
  localparam int STAT_ERR = 0;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_LCMD, SQ_LADR, SQ_LCFM, SQ_WAIT, SQ_WCMD, SQ_WADR,
    SQ_XCMD, SQ_XADR, SQ_XDAT, SQ_WGO, SQ_SCMD, SQ_SRD, SQ_FIN
  } seq_state_e;
endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_cb_pkg::*;
#(
  parameter int WLOW_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  cyc_kind_e         kind_i,
  input  logic [7:0]        byte_i,
  input  logic [WLOW_W-1:0] wlow_i,
  input  logic [7:0]        rd_i,
  output logic              ack_o,
  output logic [7:0]        rdata_o,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        io_o,
  output logic              io_oe_o
);
  typedef enum logic [1:0] {BC_IDLE, BC_LOW, BC_HOLD} bc_state_e;

  bc_state_e         st_q;
  cyc_kind_e         kind_q;
  logic [7:0]        byte_q;
  logic [7:0]        rdata_q;
  logic [WLOW_W-1:0] cnt_q;
  logic [WLOW_W-1:0] lim;
  logic              act, is_rd;

  assign lim = (wlow_i == '0) ? WLOW_W'(1) : wlow_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BC_IDLE;
      kind_q  <= CYC_CMD;
      byte_q  <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (st_q)
        BC_IDLE: if (req_i) begin
          kind_q <= kind_i;
          byte_q <= byte_i;
          cnt_q  <= WLOW_W'(1);
          st_q   <= BC_LOW;
        end
        BC_LOW: begin
          if (cnt_q >= lim) begin
            st_q <= BC_HOLD;
            if (kind_q == CYC_RD) rdata_q <= rd_i;
          end else begin
            cnt_q <= cnt_q + WLOW_W'(1);
          end
        end
        BC_HOLD: st_q <= BC_IDLE;
        default: st_q <= BC_IDLE;
      endcase
    end
  end

  assign act     = (st_q != BC_IDLE);
  assign is_rd   = (kind_q == CYC_RD);
  assign cle_o   = act && (kind_q == CYC_CMD);
  assign ale_o   = act && (kind_q == CYC_ADR);
  assign we_no   = !((st_q == BC_LOW) && !is_rd);
  assign re_no   = !((st_q == BC_LOW) && is_rd);
  assign io_oe_o = act && !is_rd;
  assign io_o    = (act && !is_rd) ? byte_q : 8'h00;
  assign ack_o   = (st_q == BC_HOLD);
  assign rdata_o = rdata_q;

  // R10
  we_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> $stable(io_o) && $stable(cle_o) && $stable(ale_o) && io_oe_o);
endmodule

// File: rtl/nand_wait_timer.sv
module nand_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (en_i && cnt_q != '1)   cnt_q <= cnt_q + TMO_W'(1);
  end

  assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/nand_copyback_seq.sv
module nand_copyback_seq
  import nand_cb_pkg::*;
#(
  parameter int ROW_BYTES = 3,
  parameter int COL_BYTES = 2,
  parameter int DIE_W     = 1,
  parameter int MAX_PATCH = 4,
  parameter int WLOW_W    = 4,
  parameter int TMO_W     = 16,
  localparam int ROW_W    = 8 * ROW_BYTES,
  localparam int COL_W    = 8 * COL_BYTES,
  localparam int CNT_W    = $clog2(MAX_PATCH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [ROW_W-1:0]           src_row_i,
  input  logic [ROW_W-1:0]           dst_row_i,
  input  logic [CNT_W-1:0]           patch_cnt_i,
  input  logic [MAX_PATCH*COL_W-1:0] patch_col_i,
  input  logic [MAX_PATCH*8-1:0]     patch_dat_i,
  input  logic                       poll_mode_i,
  input  logic [WLOW_W-1:0]          we_low_i,
  input  logic [TMO_W-1:0]           timeout_i,
  input  logic                       rb_ni,
  input  logic [7:0]                 io_i,
  output logic                       cle_o,
  output logic                       ale_o,
  output logic                       we_no,
  output logic                       re_no,
  output logic [7:0]                 io_o,
  output logic                       io_oe_o,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       pass_o,
  output logic                       die_err_o,
  output logic                       tmo_err_o
);
  localparam int ADDR_CYC = COL_BYTES + ROW_BYTES;
  localparam int IDX_W    = $clog2(ADDR_CYC);

  seq_state_e        st_q;
  logic [ROW_W-1:0]  src_q, dst_q;
  logic [CNT_W-1:0]  pcnt_q, pidx_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WLOW_W-1:0] wlow_q;
  logic              poll_q, late_q;
  logic              done_q, pass_q, die_q, tmo_q;

  logic              req, ack, expired, tmr_clr, tmr_en, die_mis;
  cyc_kind_e         kind;
  logic [7:0]        obyte, rdata;
  logic [ADDR_CYC*8-1:0] src_vec, dst_vec;
  logic [COL_W-1:0]  pcol;
  logic [7:0]        pdat;
  logic [CNT_W-1:0]  cnt_clamp;

  assign die_mis   = (src_row_i[ROW_W-1 -: DIE_W] != dst_row_i[ROW_W-1 -: DIE_W]);
  assign cnt_clamp = (int'(patch_cnt_i) > MAX_PATCH) ? CNT_W'(MAX_PATCH) : patch_cnt_i;
  assign src_vec   = {src_q, {COL_W{1'b0}}};
  assign dst_vec   = {dst_q, {COL_W{1'b0}}};
  assign pcol      = patch_col_i[int'(pidx_q)*COL_W +: COL_W];
  assign pdat      = patch_dat_i[int'(pidx_q)*8 +: 8];

  always_comb begin
    req   = 1'b1;
    kind  = CYC_CMD;
    obyte = 8'h00;
    unique case (st_q)
      SQ_LCMD: obyte = OP_LOAD;
      SQ_LADR: begin kind = CYC_ADR; obyte = src_vec[int'(idx_q)*8 +: 8]; end
      SQ_LCFM: obyte = OP_LOAD_CFM;
      SQ_WCMD: obyte = OP_WRITE;
      SQ_WADR: begin kind = CYC_ADR; obyte = dst_vec[int'(idx_q)*8 +: 8]; end
      SQ_XCMD: obyte = OP_WRITE;
      SQ_XADR: begin kind = CYC_ADR; obyte = pcol[int'(idx_q)*8 +: 8]; end
      SQ_XDAT: begin kind = CYC_DAT; obyte = pdat; end
      SQ_WGO:  obyte = OP_WRITE_GO;
      SQ_SCMD: obyte = OP_STAT;
      SQ_SRD:  kind = CYC_RD;
      default: req = 1'b0;
    endcase
  end

  assign tmr_clr = ack && (st_q == SQ_LCFM || st_q == SQ_WGO);
  assign tmr_en  = (st_q == SQ_WAIT || st_q == SQ_SCMD || st_q == SQ_SRD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SQ_IDLE;
      src_q <= '0; dst_q <= '0;
      pcnt_q <= '0; pidx_q <= '0; idx_q <= '0;
      wlow_q <= '0; poll_q <= 1'b0; late_q <= 1'b0;
      done_q <= 1'b0; pass_q <= 1'b0; die_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          pass_q <= 1'b0;
          tmo_q  <= 1'b0;
          if (die_mis) begin
            die_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            die_q  <= 1'b0;
            src_q  <= src_row_i;
            dst_q  <= dst_row_i;
            pcnt_q <= cnt_clamp;
            wlow_q <= we_low_i;
            poll_q <= poll_mode_i;
            late_q <= 1'b0;
            st_q   <= SQ_LCMD;
          end
        end
        SQ_LCMD: if (ack) begin idx_q <= '0; st_q <= SQ_LADR; end
        SQ_LADR: if (ack) begin
          if (idx_q == IDX_W'(ADDR_CYC - 1)) st_q <= SQ_LCFM;
          else idx_q <= idx_q + IDX_W'(1);
        end
        SQ_LCFM: if (ack) begin late_q <= 1'b0; st_q <= SQ_WAIT; end
        SQ_WAIT: begin
          if (poll_q)        st_q <= SQ_SCMD;
          else if (rb_ni)    st_q <= late_q ? SQ_SCMD : SQ_WCMD;
          else if (expired) begin tmo_q <= 1'b1; st_q <= SQ_FIN; end
        end
        SQ_WCMD: if (ack) begin idx_q <= '0; st_q <= SQ_WADR; end
        SQ_WADR: if (ack) begin
          if (idx_q == IDX_W'(ADDR_CYC - 1)) begin
            pidx_q <= '0;
            st_q   <= (pcnt_q != '0) ? SQ_XCMD : SQ_WGO;
          end else idx_q <= idx_q + IDX_W'(1);
        end
        SQ_XCMD: if (ack) begin idx_q <= '0; st_q <= SQ_XADR; end
        SQ_XADR: if (ack) begin
          if (idx_q == IDX_W'(COL_BYTES - 1)) st_q <= SQ_XDAT;
          else idx_q <= idx_q + IDX_W'(1);
        end
        SQ_XDAT: if (ack) begin
          if (pidx_q == pcnt_q - CNT_W'(1)) st_q <= SQ_WGO;
          else begin pidx_q <= pidx_q + CNT_W'(1); st_q <= SQ_XCMD; end
        end
        SQ_WGO:  if (ack) begin late_q <= 1'b1; st_q <= SQ_WAIT; end
        SQ_SCMD: if (ack) st_q <= SQ_SRD;
        SQ_SRD:  if (ack) begin
          if (rdata[STAT_RDY]) begin
            if (late_q) begin pass_q <= !rdata[STAT_ERR]; st_q <= SQ_FIN; end
            else st_q <= SQ_WCMD;
          end else if (expired) begin
            tmo_q <= 1'b1;
            st_q  <= SQ_FIN;
          end
        end
        SQ_FIN: begin done_q <= 1'b1; st_q <= SQ_IDLE; end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  nand_bus_cycle #(.WLOW_W(WLOW_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req),
    .kind_i  (kind),
    .byte_i  (obyte),
    .wlow_i  (wlow_q),
    .rd_i    (io_i),
    .ack_o   (ack),
    .rdata_o (rdata),
    .cle_o   (cle_o),
    .ale_o   (ale_o),
    .we_no   (we_no),
    .re_no   (re_no),
    .io_o    (io_o),
    .io_oe_o (io_oe_o)
  );

  nand_wait_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (tmr_clr),
    .en_i      (tmr_en),
    .limit_i   (timeout_i),
    .expired_o (expired)
  );

  assign busy_o    = (st_q != SQ_IDLE);
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign die_err_o = die_q;
  assign tmo_err_o = tmo_q;

  // R6
  die_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && die_mis |=> done_o && die_err_o && !busy_o && we_no);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  tmo_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_err_o |-> !pass_o);
  // R3
  rb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !poll_q && cle_o && !we_no && io_o == OP_WRITE |-> rb_ni);
endmodule

// File: tb/nand_copyback_seq_tb.sv
module nand_copyback_seq_tb;
  typedef struct packed {
    logic [23:0] src;
    logic [23:0] dst;
    logic [2:0]  np;
    logic        poll;
    logic [3:0]  wlow;
    logic [7:0]  blen;
    logic        fail;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{24'h012345, 24'h056789, 3'd0, 1'b0, 4'd1, 8'd6,  1'b0},
    '{24'h0000A1, 24'h00FF02, 3'd2, 1'b1, 4'd2, 8'd10, 1'b0},
    '{24'h7ABCDE, 24'h001122, 3'd4, 1'b0, 4'd3, 8'd3,  1'b1},
    '{24'h800010, 24'hC00020, 3'd1, 1'b1, 4'd1, 8'd20, 1'b1},
    '{24'h812345, 24'h8FEDCB, 3'd7, 1'b0, 4'd0, 8'd1,  1'b0}
  };

  logic        clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [23:0] src = '0, dst = '0;
  logic [2:0]  np = '0;
  logic        poll = 1'b0;
  logic [3:0]  wlow = 4'd1;
  logic [15:0] tmo = 16'd200;
  logic [15:0] pcol [4];
  logic [7:0]  pdat [4];
  logic [63:0] pcol_f;
  logic [31:0] pdat_f;
  logic        rb_n;
  logic [7:0]  io_in;
  logic cle, ale, we_n, re_n, oe, busy, done, pass, die_err, tmo_err;
  logic [7:0] io_out;

  int total = 0, bad = 0, cyc = 0;
  int busy_len = 5, busy_cnt = 0;
  logic fail_bit = 1'b0;

  int n_log, n_stat, n_rd, viol, len_bad, hold_bad, low_run, exp_low;
  int lk [64]; int lb [64];
  int ek [64]; int eb [64]; int ne;
  logic prev_we, prev_re, l_cle, l_ale;
  logic [7:0] l_io;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      pcol_f[16*k +: 16] = pcol[k];
      pdat_f[8*k +: 8]   = pdat[k];
    end
  end

  assign rb_n  = (busy_cnt == 0);
  assign io_in = {1'b0, (busy_cnt == 0), 5'b0, fail_bit};

  nand_copyback_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .src_row_i(src), .dst_row_i(dst),
    .patch_cnt_i(np), .patch_col_i(pcol_f), .patch_dat_i(pdat_f), .poll_mode_i(poll),
    .we_low_i(wlow), .timeout_i(tmo), .rb_ni(rb_n), .io_i(io_in),
    .cle_o(cle), .ale_o(ale), .we_no(we_n), .re_no(re_n), .io_o(io_out), .io_oe_o(oe),
    .busy_o(busy), .done_o(done), .pass_o(pass), .die_err_o(die_err), .tmo_err_o(tmo_err)
  );

  // device model and pin monitor
  always @(negedge clk) begin
    if (!rst_ni) begin
      prev_we = 1'b1; prev_re = 1'b1; busy_cnt = 0; low_run = 0;
    end else begin
      if (busy_cnt > 0) busy_cnt--;
      if (!we_n) begin
        low_run++; l_cle = cle; l_ale = ale; l_io = io_out;
      end
      if (!prev_we && we_n) begin
        if (low_run != exp_low) len_bad++;
        if (cle != l_cle || ale != l_ale || io_out != l_io) hold_bad++;
        if (cle && io_out == 8'h85 && busy_cnt != 0) viol++;
        if (cle && (io_out == 8'h35 || io_out == 8'h10)) busy_cnt = busy_len;
        if (cle && io_out == 8'h70) n_stat++;
        else if (n_log < 64) begin
          lk[n_log] = cle ? 0 : (ale ? 1 : 2);
          lb[n_log] = int'(io_out);
          n_log++;
        end
        low_run = 0;
      end
      if (!prev_re && re_n) n_rd++;
      prev_we = we_n; prev_re = re_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int got, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, expv);
    end
  endtask

  task automatic clr_mon();
    n_log = 0; n_stat = 0; n_rd = 0; viol = 0; len_bad = 0; hold_bad = 0;
    exp_low = (wlow == 0) ? 1 : int'(wlow);
  endtask

  task automatic push(input int k, input int b);
    ek[ne] = k; eb[ne] = b; ne++;
  endtask

  task automatic build_exp(input int npe);
    ne = 0;
    push(0, 8'h00); push(1, 0); push(1, 0);
    for (int i = 0; i < 3; i++) push(1, int'(src[8*i +: 8]));
    push(0, 8'h35);
    push(0, 8'h85); push(1, 0); push(1, 0);
    for (int i = 0; i < 3; i++) push(1, int'(dst[8*i +: 8]));
    for (int k = 0; k < npe; k++) begin
      push(0, 8'h85); push(1, int'(pcol[k][7:0])); push(1, int'(pcol[k][15:8]));
      push(2, int'(pdat[k]));
    end
    push(0, 8'h10);
  endtask

  function automatic bit seg_ok(input int lo, input int hi);
    for (int i = lo; i <= hi; i++)
      if (i >= n_log || lk[i] != ek[i] || lb[i] != eb[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic fire_and_wait(output bit seen);
    int n;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    seen = done;
  endtask

  task automatic set_patches();
    for (int k = 0; k < 4; k++) begin
      pcol[k] = {8'(k + 1), 8'(src[7:0] + 8'(k))};
      pdat[k] = dst[7:0] ^ 8'(k * 17);
    end
  endtask

  initial begin
    bit seen;
    for (int k = 0; k < 4; k++) begin pcol[k] = '0; pdat[k] = '0; end
    clr_mon();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(we_n && re_n && !cle && !ale && !oe, "R1 bus idle in reset", {we_n, re_n, cle, ale, oe}, 5'b11000);
    chk(!done && !busy, "R1 flags in reset", {done, busy}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(we_n && re_n && !cle && !ale && !oe && !busy, "R1 idle after reset", {we_n, busy}, 2'b10);

    for (int v = 0; v < NV; v++) begin
      int npe;
      src = VEC[v].src; dst = VEC[v].dst; np = VEC[v].np; poll = VEC[v].poll;
      wlow = VEC[v].wlow; busy_len = int'(VEC[v].blen); fail_bit = VEC[v].fail;
      tmo = 16'd200;
      set_patches();
      npe = (int'(np) > 4) ? 4 : int'(np);
      build_exp(npe);
      clr_mon();
      fire_and_wait(seen);
      chk(seen, "R11 done seen", int'(seen), 1);
      @(negedge clk);
      chk(!done, "R11 done one clock", int'(done), 0);
      chk(pass == !VEC[v].fail, "R8 pass flag", int'(pass), int'(!VEC[v].fail));
      chk(!tmo_err && !die_err, "R9 no spurious error", {tmo_err, die_err}, 0);
      chk(seg_ok(0, 6), "R2 load sequence", n_log, 7);
      chk(seg_ok(7, 12) && seg_ok(ne - 1, ne - 1) && n_log == ne, "R4 write sequence", n_log, ne);
      chk(seg_ok(13, ne - 2), "R5 patches", n_log, ne);
      chk(viol == 0, "R3 85h while busy", viol, 0);
      if (poll) chk(n_stat == 2 && n_rd >= 2, "R7 poll mode status", n_stat, 2);
      else      chk(n_stat == 1 && n_rd == 1, "R7 rb mode status", n_stat * 16 + n_rd, 17);
      chk(len_bad == 0 && hold_bad == 0, "R10 strobe width and hold", len_bad + hold_bad, 0);
      repeat (5) @(negedge clk);
    end

    // R6 die mismatch
    src = 24'h000001; dst = 24'h800001; clr_mon();
    fire_and_wait(seen);
    chk(seen && die_err, "R6 die error flagged", int'(die_err), 1);
    repeat (20) @(negedge clk);
    chk(n_log == 0 && n_stat == 0 && n_rd == 0 && !busy, "R6 no bus cycles", n_log, 0);

    // R9 timeout after 35h, ready/busy mode
    src = 24'h010203; dst = 24'h040506; np = 3'd1; poll = 1'b0; wlow = 4'd1;
    busy_len = 250; tmo = 16'd40; fail_bit = 1'b0; clr_mon();
    fire_and_wait(seen);
    chk(seen && tmo_err && !pass, "R9 timeout rb mode", {tmo_err, pass}, 2'b10);
    repeat (300) @(negedge clk);
    chk(n_log == 7 && n_stat == 0, "R9 nothing after timeout", n_log, 7);

    // R9 timeout while polling
    poll = 1'b1; clr_mon();
    fire_and_wait(seen);
    chk(seen && tmo_err && !pass, "R9 timeout poll mode", {tmo_err, pass}, 2'b10);
    repeat (300) @(negedge clk);
    chk(n_log == 7, "R9 no write after poll timeout", n_log, 7);

    // R11 start ignored while busy
    src = 24'h012345; dst = 24'h056789; np = 3'd0; poll = 1'b0; wlow = 4'd2;
    busy_len = 8; tmo = 16'd200; build_exp(0); clr_mon();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    src = 24'h000001; dst = 24'h800001;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    src = 24'h012345; dst = 24'h056789;
    begin
      int n = 0;
      while (!done && n < 20000) begin @(negedge clk); n++; end
    end
    chk(done && !die_err && pass, "R11 start while busy ignored", {done, die_err, pass}, 3'b101);
    chk(n_log == ne && seg_ok(0, ne - 1), "R11 sequence intact", n_log, ne);
    repeat (10) @(negedge clk);
    chk(pass && !busy && !done, "R11 result held", {pass, busy, done}, 3'b100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    total++; bad++;
    $display("FAIL watchdog expired got=%0d exp=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule